// File: doc/BRIEF.md
# Stream Channel Select, Decimate and Format

This block feeds one acquisition output stream. A 5-bit source code picks one of up to thirty channel sample buses, or an internal counter for test, or nothing at all. The chosen samples are then re-formatted to a programmable sign-extension point. They are thinned by a programmable rate divider, which either keeps one sample per window or averages the window. Finally they are issued either as full 32-bit words or as pairs of 16-bit halves packed into one word.

Each channel brings a 32-bit sample bus and a valid strobe. Configuration arrives as plain level inputs. The stream is expected to be disabled (source code 0) while the divider, averaging, width or sign settings are changed. Disabling the stream drops any half-filled window or half-filled pair. The output is a 32-bit word with a one-cycle valid strobe. A registered copy of the chosen source's valid is also provided as a status flag.

Top module: `chsel_decim_fmt`

## Requirements
- R1: With source code 0 the stream is off: `out_valid` and `sel_valid` stay 0. After reset `out_valid`, `sel_valid` and `out_data` are 0.
- R2: Source code 1 selects the test counter. It starts at 0 when test mode begins, supplies a valid sample every cycle, and rises by one each cycle.
- R3: Source code n+2 selects channel n (n = 0..29), and that channel's valid qualifies its samples. Channel n occupies bits n*32+31 down to n*32 of `ch_data`.
- R4: `sel_valid` shows, one clock edge later, the valid of the chosen source. It is the channel valid for codes 2 and up, constant 1 in test mode and 0 when off.
- R5: A divider value of 0 or 1 passes every valid sample to the output.
- R6: With divider D of 2 or more and averaging off, each run of D valid samples, counted from enable, yields one result: the last sample of that run.
- R7: With divider D of 2 or more and averaging on, the result is the sum of the run's D formatted samples shifted right by floor(log2 D). The shift is arithmetic when signed mode is set and logical otherwise. Only the low 32 bits are kept.
- R8: Formatting keeps bits P..0 of a sample, where P is the 5-bit sign position. Every bit above P becomes a copy of bit P in signed mode and 0 in unsigned mode. Formatting happens before decimation.
- R9: In 32-bit mode (`cfg_wide`=1) each result is one output word. In 16-bit mode two results form one word: bits 15:0 of the earlier one in bits 15:0 and bits 15:0 of the later one in bits 31:16.
- R10: A sample taken at clock edge E, with divider 1 and 32-bit mode, appears with `out_valid` after edge E+2. Every completed result is delivered after the stream is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_data | input | NUM_CH*32 | Channel sample buses, channel n in slice n |
| ch_valid | input | NUM_CH | Per-channel sample valid |
| cfg_sel | input | 5 | Source code: 0 off, 1 test counter, n+2 channel n |
| cfg_div | input | 16 | Rate divider |
| cfg_avg | input | 1 | 1 averages the window, 0 keeps its last sample |
| cfg_sign_pos | input | 5 | Sign-extension bit position |
| cfg_wide | input | 1 | 1 for 32-bit words, 0 for packed 16-bit pairs |
| cfg_signed | input | 1 | 1 for signed interpretation |
| out_data | output | 32 | Formatted output word |
| out_valid | output | 1 | Output word strobe |
| sel_valid | output | 1 | Registered valid of the chosen source |

## Verification
The status flag is due one edge after a sample is driven, and it is compared at the next falling edge. A word travels through three registers: the source stage, the format-and-decimate stage and the packing stage. It is therefore due after the second edge that follows its sampling edge. A directed case drives one sample and checks that `out_valid` is low at the first two falling edges and that the word is present at the third. Random phases compare the output words in order against a queue filled by bench functions. In these phases the timing is left to the ordering, and at each disable the bench confirms that the queue has drained.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
   localparam int SEL_OFF  = 0;
   localparam int SEL_TEST = 1;
   localparam int SEL_BASE = 2;
   localparam int SEL_W    = 5;
endpackage

// File: rtl/chsel_select.sv
module chsel_select
   import chsel_pkg::*;
#(
   parameter int NUM_CH = 30,
   parameter int DATA_W = 32
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*DATA_W-1:0] ch_data,
   input  logic [NUM_CH-1:0]        ch_valid,
   input  logic [SEL_W-1:0]         sel,
   output logic                     src_en,
   output logic                     src_vld,
   output logic [DATA_W-1:0]        src_data
);
   logic [DATA_W-1:0] lane [NUM_CH];
   logic [DATA_W-1:0] pick_d;
   logic              pick_v;
   logic [SEL_W-1:0]  idx;
   logic [DATA_W-1:0] tcnt;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      assign lane[g] = ch_data[g*DATA_W +: DATA_W];
   end

   assign idx = sel - SEL_W'(SEL_BASE);

   always_comb begin
      pick_d = '0;
      pick_v = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel >= SEL_W'(SEL_BASE) && idx == SEL_W'(i)) begin
            pick_d = lane[i];
            pick_v = ch_valid[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_en   <= 1'b0;
         src_vld  <= 1'b0;
         src_data <= '0;
         tcnt     <= '0;
      end else begin
         src_en <= (sel != SEL_W'(SEL_OFF));
         if (sel == SEL_W'(SEL_TEST)) begin
            src_vld  <= 1'b1;
            src_data <= tcnt;
            tcnt     <= tcnt + 1'b1;
         end else begin
            tcnt    <= '0;
            src_vld <= pick_v;
            if (pick_v) src_data <= pick_d;
         end
      end
   end

   // R1
   off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(SEL_OFF)) |=> (!src_vld && !src_en));

   // R2
   test_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(SEL_TEST) && $past(sel) == SEL_W'(SEL_TEST) && $past(rst_n))
      |=> (src_vld && src_data == $past(src_data) + 1'b1));
endmodule

// File: rtl/chsel_format.sv
module chsel_format #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
)(
   input  logic [DATA_W-1:0] din,
   input  logic [POS_W-1:0]  pos,
   input  logic              sgn,
   output logic [DATA_W-1:0] dout
);
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         if (POS_W'(i) <= pos) dout[i] = din[i];
         else                  dout[i] = sgn & din[pos];
      end
   end
endmodule

// File: rtl/chsel_decim.sv
module chsel_decim #(
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 16,
   parameter bit HAS_AVG = 1'b1,
   localparam int ACC_W  = DATA_W + DIV_W,
   localparam int SH_W   = $clog2(DIV_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DIV_W-1:0]  div,
   input  logic              avg,
   input  logic              sgn,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   logic [DIV_W-1:0]  cnt;
   logic              last;
   logic [SH_W-1:0]   sh;
   logic [DATA_W-1:0] avg_val;

   assign last = (div <= DIV_W'(1)) || (cnt == div - DIV_W'(1));

   always_comb begin
      sh = '0;
      for (int i = 0; i < DIV_W; i++) if (div[i]) sh = SH_W'(i);
   end

   if (HAS_AVG) begin : g_avg
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] sum;
      always_comb begin
         if (sgn) sum = acc + {{DIV_W{in_data[DATA_W-1]}}, in_data};
         else     sum = acc + {{DIV_W{1'b0}}, in_data};
         if (sgn) avg_val = DATA_W'($signed(sum) >>> sh);
         else     avg_val = DATA_W'(sum >> sh);
      end
      always_ff @(posedge clk) begin
         if (!rst_n || !en)   acc <= '0;
         else if (in_vld)     acc <= last ? '0 : sum;
      end
   end else begin : g_pick
      assign avg_val = in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (!en) begin
         cnt     <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (in_vld) begin
            if (last) begin
               cnt      <= '0;
               out_vld  <= 1'b1;
               out_data <= (avg && div > DIV_W'(1)) ? avg_val : in_data;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R5
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && in_vld && div <= DIV_W'(1)) |=> out_vld);

   // R6
   pick_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !$past(avg) && $past(div) > DIV_W'(1)) |-> (out_data == $past(in_data)));
endmodule

// File: rtl/chsel_pack.sv
module chsel_pack #(
   parameter int DATA_W = 32,
   localparam int HALF  = DATA_W / 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wide,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   logic [HALF-1:0] lo;
   logic            phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo       <= '0;
         phase    <= 1'b0;
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (!en) begin
         phase   <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (in_vld) begin
            if (wide) begin
               out_data <= in_data;
               out_vld  <= 1'b1;
               phase    <= 1'b0;
            end else if (!phase) begin
               lo    <= in_data[HALF-1:0];
               phase <= 1'b1;
            end else begin
               out_data <= {in_data[HALF-1:0], lo};
               out_vld  <= 1'b1;
               phase    <= 1'b0;
            end
         end
      end
   end

   // R9
   half_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wide && in_vld && !phase) |=> !out_vld);

   // R9
   wide_each_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wide && in_vld) |=> (out_vld && out_data == $past(in_data)));
endmodule

// File: rtl/chsel_decim_fmt.sv
module chsel_decim_fmt
   import chsel_pkg::*;
#(
   parameter int NUM_CH  = 30,
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 16,
   parameter bit HAS_AVG = 1'b1,
   localparam int POS_W  = $clog2(DATA_W)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*DATA_W-1:0] ch_data,
   input  logic [NUM_CH-1:0]        ch_valid,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic [DIV_W-1:0]         cfg_div,
   input  logic                     cfg_avg,
   input  logic [POS_W-1:0]         cfg_sign_pos,
   input  logic                     cfg_wide,
   input  logic                     cfg_signed,
   output logic [DATA_W-1:0]        out_data,
   output logic                     out_valid,
   output logic                     sel_valid
);
   if (NUM_CH < 1 || NUM_CH + SEL_BASE > (1 << SEL_W)) begin : g_bad_ch
      $error("NUM_CH does not fit the source code");
   end
   if (DATA_W < 4 || DATA_W % 2 != 0) begin : g_bad_dw
      $error("DATA_W must be even and at least 4");
   end
   if (DIV_W < 2 || DIV_W > 32) begin : g_bad_div
      $error("DIV_W out of range");
   end

   logic              s1_en, s1_vld, s2_en, s2_vld;
   logic [DATA_W-1:0] s1_data, s1_fmt, s2_data;

   chsel_select #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_valid(ch_valid),
      .sel(cfg_sel), .src_en(s1_en), .src_vld(s1_vld), .src_data(s1_data));

   chsel_format #(.DATA_W(DATA_W)) u_fmt (
      .din(s1_data), .pos(cfg_sign_pos), .sgn(cfg_signed), .dout(s1_fmt));

   chsel_decim #(.DATA_W(DATA_W), .DIV_W(DIV_W), .HAS_AVG(HAS_AVG)) u_dec (
      .clk(clk), .rst_n(rst_n), .en(s1_en), .in_vld(s1_vld), .in_data(s1_fmt),
      .div(cfg_div), .avg(cfg_avg), .sgn(cfg_signed),
      .out_vld(s2_vld), .out_data(s2_data));

   always_ff @(posedge clk) begin
      if (!rst_n) s2_en <= 1'b0;
      else        s2_en <= s1_en;
   end

   chsel_pack #(.DATA_W(DATA_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .en(s2_en), .wide(cfg_wide),
      .in_vld(s2_vld), .in_data(s2_data),
      .out_vld(out_valid), .out_data(out_data));

   assign sel_valid = s1_vld;

   // R10
   drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s1_en && !s2_en && !s2_vld) |=> !out_valid);
endmodule

// File: tb/tb_chsel_decim_fmt.sv
module tb_chsel_decim_fmt;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 30;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NCH*32-1:0] ch_data;
   logic [NCH-1:0]    ch_valid;
   logic [4:0]        cfg_sel, cfg_sign_pos;
   logic [15:0]       cfg_div;
   logic              cfg_avg, cfg_wide, cfg_signed;
   logic [31:0]       out_data;
   logic              out_valid, sel_valid;

   chsel_decim_fmt dut (
      .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_valid(ch_valid),
      .cfg_sel(cfg_sel), .cfg_div(cfg_div), .cfg_avg(cfg_avg),
      .cfg_sign_pos(cfg_sign_pos), .cfg_wide(cfg_wide), .cfg_signed(cfg_signed),
      .out_data(out_data), .out_valid(out_valid), .sel_valid(sel_valid));

   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0, errors = 0;
   logic [31:0] expq[$];
   int          m_cnt;
   longint      m_acc;
   logic [15:0] m_lo;
   bit          m_ph;
   logic [31:0] tcnt;
   logic        exp_sv;
   string       cur_tag;
   logic [4:0]  n_sel, n_pos;
   logic [15:0] n_div;
   logic        n_avg, n_wide, n_sgn;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] fmt(input logic [31:0] x, input logic [4:0] p, input logic s);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (i <= int'(p)) ? x[i] : (s & x[p]);
      return r;
   endfunction

   function automatic int flog2(input logic [15:0] d);
      int r = 0;
      for (int i = 0; i < 16; i++) if (d[i]) r = i;
      return r;
   endfunction

   task automatic emit(input logic [31:0] v);
      if (cfg_wide) expq.push_back(v);
      else if (!m_ph) begin m_lo = v[15:0]; m_ph = 1'b1; end
      else begin expq.push_back({v[15:0], m_lo}); m_ph = 1'b0; end
   endtask

   task automatic model_push(input logic [31:0] s);
      logic [31:0] f;
      f = fmt(s, cfg_sign_pos, cfg_signed);
      if (cfg_div <= 16'd1) emit(f);
      else begin
         if (cfg_signed) m_acc += longint'($signed(f));
         else            m_acc += longint'({32'b0, f});
         m_cnt++;
         if (m_cnt == int'(cfg_div)) begin
            if (cfg_avg) emit(32'(m_acc >>> flog2(cfg_div)));
            else         emit(f);
            m_cnt = 0;
            m_acc = 0;
         end
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_acc = 0; m_ph = 1'b0; m_lo = '0; tcnt = '0;
   endtask

   task automatic step();
      @(negedge clk);
      chk(sel_valid === exp_sv, "R4", {31'b0, sel_valid}, {31'b0, exp_sv});
      if (out_valid) begin
         if (expq.size() == 0) chk(1'b0, (cfg_sel == 5'd0) ? "R1" : cur_tag, out_data, 32'h0);
         else begin
            logic [31:0] e;
            e = expq.pop_front();
            chk(out_data === e, cur_tag, out_data, e);
         end
      end
      cfg_sel = n_sel; cfg_div = n_div; cfg_avg = n_avg;
      cfg_sign_pos = n_pos; cfg_wide = n_wide; cfg_signed = n_sgn;
      for (int i = 0; i < NCH; i++) ch_data[i*32 +: 32] = $urandom;
      ch_valid = NCH'({$urandom, $urandom});
      exp_sv = 1'b0;
      if (cfg_sel == 5'd1) begin
         exp_sv = 1'b1;
         model_push(tcnt);
         tcnt = tcnt + 1;
      end else if (cfg_sel >= 5'd2) begin
         int k;
         k = int'(cfg_sel) - 2;
         exp_sv = ch_valid[k];
         if (ch_valid[k]) model_push(ch_data[k*32 +: 32]);
      end
   endtask

   function automatic string tag_of(input logic [4:0] s, input logic [15:0] d, input logic a,
                                    input logic w, input logic [4:0] p);
      if (s == 5'd0)                return "R1";
      if (s == 5'd1)                return "R2";
      if (a && d > 16'd1)           return "R7";
      if (d > 16'd1)                return "R6";
      if (!w)                       return "R9";
      if (p != 5'd31)               return "R8";
      if (d == 16'd0)               return "R5";
      return "R3";
   endfunction

   task automatic run_phase(input logic [4:0] s, input logic [15:0] d, input logic a,
                            input logic [4:0] p, input logic w, input logic sg, input int n);
      n_sel = 5'd0;
      for (int i = 0; i < 4; i++) step();
      // R10: completed words all delivered after disable
      chk(expq.size() == 0, "R10", expq.size(), 0);
      expq.delete();
      model_reset();
      cur_tag = tag_of(s, d, a, w, p);
      n_sel = s; n_div = d; n_avg = a; n_pos = p; n_wide = w; n_sgn = sg;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      ch_data = '0; ch_valid = '0;
      cfg_sel = 5'd0; cfg_div = 16'd1; cfg_avg = 1'b0;
      cfg_sign_pos = 5'd31; cfg_wide = 1'b1; cfg_signed = 1'b0;
      n_sel = 5'd0; n_div = 16'd1; n_avg = 1'b0; n_pos = 5'd31; n_wide = 1'b1; n_sgn = 1'b0;
      exp_sv = 1'b0; cur_tag = "R1";
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0, "R1", {31'b0, out_valid}, 32'h0);
      chk(sel_valid === 1'b0, "R1", {31'b0, sel_valid}, 32'h0);
      chk(out_data === 32'h0, "R1", out_data, 32'h0);

      // R10: directed latency, channel 0, divider 1, 32-bit
      cfg_sel = 5'd2; ch_valid = '0; ch_valid[0] = 1'b1; ch_data[31:0] = 32'hA5C3_1E0F;
      @(negedge clk);
      chk(out_valid === 1'b0, "R10", {31'b0, out_valid}, 32'h0);
      chk(sel_valid === 1'b1, "R4", {31'b0, sel_valid}, 32'h1);
      ch_valid = '0;
      @(negedge clk);
      chk(out_valid === 1'b0, "R10", {31'b0, out_valid}, 32'h0);
      cfg_sel = 5'd0;
      @(negedge clk);
      chk(out_valid === 1'b1, "R10", {31'b0, out_valid}, 32'h1);
      chk(out_data === 32'hA5C3_1E0F, "R10", out_data, 32'hA5C3_1E0F);
      exp_sv = 1'b0;

      run_phase(5'd2,  16'd1, 1'b0, 5'd31, 1'b1, 1'b0, 300);  // R3
      run_phase(5'd12, 16'd0, 1'b0, 5'd31, 1'b1, 1'b0, 300);  // R5
      run_phase(5'd31, 16'd4, 1'b0, 5'd15, 1'b1, 1'b1, 400);  // R6
      run_phase(5'd7,  16'd4, 1'b1, 5'd11, 1'b1, 1'b1, 400);  // R7
      run_phase(5'd10, 16'd3, 1'b1, 5'd31, 1'b1, 1'b0, 400);  // R7 truncating
      run_phase(5'd9,  16'd1, 1'b0, 5'd11, 1'b1, 1'b1, 300);  // R8
      run_phase(5'd20, 16'd1, 1'b0, 5'd20, 1'b1, 1'b0, 300);  // R8
      run_phase(5'd1,  16'd1, 1'b0, 5'd31, 1'b1, 1'b0, 300);  // R2
      run_phase(5'd1,  16'd2, 1'b1, 5'd31, 1'b0, 1'b0, 300);  // R2 averaged, packed
      run_phase(5'd5,  16'd0, 1'b0, 5'd7,  1'b0, 1'b1, 300);  // R9
      run_phase(5'd0,  16'd1, 1'b0, 5'd31, 1'b1, 1'b0, 100);  // R1
      for (int r = 0; r < 8; r++)
         run_phase(5'($urandom_range(0, 31)), 16'($urandom_range(0, 9)), 1'($urandom),
                   5'($urandom_range(0, 31)), 1'($urandom), 1'($urandom), 400);
      n_sel = 5'd0;
      for (int i = 0; i < 4; i++) step();
      // R10: final drain
      chk(expq.size() == 0, "R10", expq.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule